// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block collects peripheral interrupt lines and drives two exception requests toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each level has four registers. The raw-signal register follows the lines. The enable mask is set by writing ones. A disable port clears enable bits by writing ones. The active-status register is the raw signal gated by the enable mask. Both outputs are a plain OR over their active status. There is no priority encoding and no vector output, so the handler software scans the active-status register.

Source bit 0 is not an external line on either level. It is the combined fast request, so a pending fast request can also be routed to the normal level. Source bit 1 on each level is a programmed interrupt set from a software-interrupt register, and no enable mask can hide it. A single bit can never be enabled on both levels at once: enabling it on one level removes it from the other.

External lines pass through a two-flop synchronizer, and both outputs are registered. Register access uses a simple synchronous port: a write takes effect at the clock edge, and read data appears in the cycle after `reg_re`. The port has no handshake or back-pressure. Every access completes in one cycle, and `reg_rdata` holds its value until the next read.

Top module: `irq_fiq_ctrl`

Register map (word addresses on `reg_addr`): 0 normal raw, 1 normal enable (write-one-to-set, readable), 2 normal disable (write-one-to-clear), 3 normal active, 4 fast raw, 5 fast enable, 6 fast disable, 7 fast active, 8 software-interrupt. All other addresses are unmapped.

## Requirements
- R1: The raw-signal bit n (n ≥ 2) of both levels equals `src_i[n]` delayed by two clocks through a synchronizer. Bits at or above NSRC read as zero.
- R2: The active-status register of each level equals its raw signal ANDed with its enable mask. Bit 1 is the exception (see R7).
- R3: `irq_o` is a register that holds the OR of all normal active-status bits from the previous cycle. A source change reaches `irq_o` on the third rising edge.
- R4: `fiq_o` is the registered OR of fast active-status bits NSRC-1..1. The unregistered value of that OR is raw bit 0 of both levels.
- R5: Writing an enable address sets the bits written as 1 and keeps the bits written as 0. Writing a disable address clears the bits written as 1 and keeps the rest. Reading a disable address returns 0.
- R6: Setting a bit in one enable mask clears the same bit in the other mask. If both masks are set for one bit in the same cycle, the fast level keeps it. A bit may be clear in both masks.
- R7: Software-interrupt register bit 1 drives raw and active bit 1 of the normal level. Bit 2 drives raw and active bit 1 of the fast level, whatever the masks hold. All other bits of this register are not stored and read 0.
- R8: After reset both masks and the software-interrupt register are 0, and both outputs are low.
- R9: Writes to raw, active and unmapped addresses change no state. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC-2 | Peripheral lines for source bits NSRC-1..2 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with NSRC = 12, which is narrower than the 32-bit data path. This makes it possible to check that mask writes and raw reads above the source count stay zero. The narrow width also lets random line patterns hit both a single active source and all sources active. A behavioural model is compared against both outputs and the read data on every clock. It covers the three-clock path from a source to an output, the routing of the fast request onto bit 0, and enables that conflict between levels.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_NRM_RAW = 4'd0;
  localparam logic [ADDR_W-1:0] A_NRM_ENA = 4'd1;
  localparam logic [ADDR_W-1:0] A_NRM_DIS = 4'd2;
  localparam logic [ADDR_W-1:0] A_NRM_ACT = 4'd3;
  localparam logic [ADDR_W-1:0] A_FST_RAW = 4'd4;
  localparam logic [ADDR_W-1:0] A_FST_ENA = 4'd5;
  localparam logic [ADDR_W-1:0] A_FST_DIS = 4'd6;
  localparam logic [ADDR_W-1:0] A_FST_ACT = 4'd7;
  localparam logic [ADDR_W-1:0] A_SWINT   = 4'd8;

  localparam int SW_NRM_BIT = 1;
  localparam int SW_FST_BIT = 2;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/irq_mask_pair.sv
module irq_mask_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nrm_set_i,
  input  logic [W-1:0] nrm_clr_i,
  input  logic [W-1:0] fst_set_i,
  input  logic [W-1:0] fst_clr_i,
  output logic [W-1:0] nrm_en_o,
  output logic [W-1:0] fst_en_o
);
  logic [W-1:0] nrm_q, fst_q;
  logic [W-1:0] nrm_d, fst_d;
  logic [W-1:0] nrm_win;

  always_comb begin
    nrm_win = nrm_set_i & ~fst_set_i;
    nrm_d   = (nrm_q | nrm_set_i) & ~nrm_clr_i & ~fst_set_i;
    fst_d   = (fst_q | fst_set_i) & ~fst_clr_i & ~nrm_win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrm_q <= '0;
      fst_q <= '0;
    end else begin
      nrm_q <= nrm_d;
      fst_q <= fst_d;
    end
  end

  assign nrm_en_o = nrm_q;
  assign fst_en_o = fst_q;

  assert_en_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_q & fst_q) == '0);

  assert_clr_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_clr_i != '0) |=> ((nrm_q & $past(nrm_clr_i)) == '0));

  assert_fast_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fst_set_i != '0) && (fst_clr_i == '0)) |=> ((fst_q & $past(fst_set_i)) == $past(fst_set_i)));
endmodule

// File: rtl/irq_level_core.sv
module irq_level_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:2] ext_i,
  input  logic         swi_i,
  input  logic         fb_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] act_o,
  output logic         hi_req_o
);
  logic [W-1:1] raw_hi;
  logic [W-1:1] act_hi;

  for (genvar b = 1; b < W; b++) begin : g_bit
    if (b == 1) begin : g_soft
      assign raw_hi[b] = swi_i;
      assign act_hi[b] = swi_i;
    end else begin : g_line
      assign raw_hi[b] = ext_i[b];
      assign act_hi[b] = ext_i[b] & en_i[b];
    end
  end

  assign hi_req_o = |act_hi;
  assign raw_o    = {raw_hi, fb_i};
  assign act_o    = {act_hi, fb_i & en_i[0]};

  assert_act_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o & ~raw_o) == '0);

  assert_soft_nonmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swi_i |-> act_o[1]);
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:2]   src_i,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int W = NSRC;

  logic [W-1:2] sync_q;
  logic [W-1:0] wmask;
  logic [W-1:0] n_set, n_clr, f_set, f_clr;
  logic [W-1:0] n_en, f_en;
  logic [W-1:0] n_raw, n_act, f_raw, f_act;
  logic         n_hi, f_hi;
  logic [2:1]   swi_q;
  logic         irq_q, fiq_q;
  logic [DATA_W-1:0] rd_mux, rd_q;

  irq_src_sync #(.W(W-2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_q)
  );

  assign wmask = reg_wdata[W-1:0];

  always_comb begin
    n_set = '0; n_clr = '0; f_set = '0; f_clr = '0;
    if (reg_we) begin
      unique case (reg_addr)
        A_NRM_ENA: n_set = wmask;
        A_NRM_DIS: n_clr = wmask;
        A_FST_ENA: f_set = wmask;
        A_FST_DIS: f_clr = wmask;
        default: ;
      endcase
    end
  end

  irq_mask_pair #(.W(W)) u_masks (
    .clk(clk), .rst_n(rst_n),
    .nrm_set_i(n_set), .nrm_clr_i(n_clr),
    .fst_set_i(f_set), .fst_clr_i(f_clr),
    .nrm_en_o(n_en), .fst_en_o(f_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) swi_q <= '0;
    else if (reg_we && reg_addr == A_SWINT)
      swi_q <= {reg_wdata[SW_FST_BIT], reg_wdata[SW_NRM_BIT]};
  end

  irq_level_core #(.W(W)) u_fast (
    .clk(clk), .rst_n(rst_n), .ext_i(sync_q), .swi_i(swi_q[2]),
    .fb_i(f_hi), .en_i(f_en), .raw_o(f_raw), .act_o(f_act), .hi_req_o(f_hi)
  );

  irq_level_core #(.W(W)) u_norm (
    .clk(clk), .rst_n(rst_n), .ext_i(sync_q), .swi_i(swi_q[1]),
    .fb_i(f_hi), .en_i(n_en), .raw_o(n_raw), .act_o(n_act), .hi_req_o(n_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= n_hi | n_act[0];
      fiq_q <= f_hi;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_NRM_RAW: rd_mux[W-1:0] = n_raw;
      A_NRM_ENA: rd_mux[W-1:0] = n_en;
      A_NRM_ACT: rd_mux[W-1:0] = n_act;
      A_FST_RAW: rd_mux[W-1:0] = f_raw;
      A_FST_ENA: rd_mux[W-1:0] = f_en;
      A_FST_ACT: rd_mux[W-1:0] = f_act;
      A_SWINT: begin
        rd_mux[SW_NRM_BIT] = swi_q[1];
        rd_mux[SW_FST_BIT] = swi_q[2];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else if (reg_re) rd_q <= rd_mux;
  end

  assign reg_rdata = rd_q;
  assign irq_o     = irq_q;
  assign fiq_o     = fiq_q;

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(n_act != '0));

  assert_fiq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(f_act[W-1:1] != '0));

  assert_fb_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    n_raw[0] == f_raw[0]);
endmodule

// File: tb/irq_fiq_ctrl_bench.sv
module irq_fiq_ctrl_bench;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:2] src = '0;
  logic we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  string rtag = "R8";
  string cur_tag = "R8";

  always #5 clk = ~clk;

  irq_fiq_ctrl #(.NSRC(N)) u_irq_fiq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_re(re),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // behavioural reference model
  logic [31:0] m_s1, m_s2, m_ne, m_fe;
  logic [2:0]  m_sw;
  logic        e_irq, e_fiq;
  logic [31:0] e_rd;
  logic [31:0] lim;

  always @(posedge clk) begin
    logic [31:0] fraw, nraw, fact, nact, w;
    logic fq;
    lim = (32'h1 << N) - 1;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ne = 0; m_fe = 0; m_sw = 0;
      e_irq = 0; e_fiq = 0; e_rd = 0;
    end else begin
      fraw = m_s2; fraw[1] = m_sw[2];
      fact = fraw & m_fe; fact[1] = m_sw[2]; fact[0] = 1'b0;
      fq = (fact != 0);
      fraw[0] = fq; fact[0] = fq & m_fe[0];
      nraw = m_s2; nraw[1] = m_sw[1]; nraw[0] = fq;
      nact = nraw & m_ne; nact[1] = m_sw[1];
      if (re) begin
        rtag = cur_tag;
        case (addr)
          0: e_rd = nraw;  1: e_rd = m_ne;  3: e_rd = nact;
          4: e_rd = fraw;  5: e_rd = m_fe;  7: e_rd = fact;
          8: e_rd = {29'd0, m_sw[2:1], 1'b0};
          default: e_rd = 0;
        endcase
      end
      e_irq = (nact != 0);
      e_fiq = fq;
      w = wdata & lim;
      if (we) case (addr)
        1: begin m_ne = m_ne | w; m_fe = m_fe & ~w; end
        2: m_ne = m_ne & ~w;
        5: begin m_fe = m_fe | w; m_ne = m_ne & ~w; end
        6: m_fe = m_fe & ~w;
        8: m_sw = {wdata[2:1], 1'b0};
        default: ;
      endcase
      m_s2 = m_s1;
      m_s1 = {20'd0, src, 2'b00} & lim;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R3 irq_o", {31'd0, irq}, {31'd0, e_irq});
    chk("R4 fiq_o", {31'd0, fiq}, {31'd0, e_fiq});
    chk(rtag, rdata, e_rd);
  end

  task automatic op(input bit w, input bit r, input logic [3:0] a,
                    input logic [31:0] d, input string tag);
    @(posedge clk); #2;
    we = w; re = r; addr = a; wdata = d; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, "R9 hold");
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 10; a++) op(0, 1, 4'(a), 0, tag);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R8 irq_o after reset", {31'd0, irq}, 0);
    chk("R8 fiq_o after reset", {31'd0, fiq}, 0);
    started = 1;
    rd_all("R8 reset readback");

    // R1/R2/R3: normal enable and a single line
    op(1, 0, 1, 32'h0000_0024, "R5 ena write");
    @(posedge clk); #2 src = 10'b0000001000; we = 0;
    idle(5);
    rd_all("R1 R2 single line");
    src = '1;
    idle(4);
    rd_all("R2 all lines");
    // R5 disable port
    op(1, 0, 2, 32'h0000_0004, "R5 dis write");
    idle(3);
    rd_all("R5 after disable");
    // R6 conflict
    op(1, 0, 5, 32'h0000_0021, "R6 fast enable");
    idle(3);
    rd_all("R6 R4 exclusion readback");
    op(1, 0, 1, 32'h0000_0001, "R4 route fast to normal");
    idle(3);
    rd_all("R4 bit0 feedback");
    // R7 software interrupts with masks cleared
    op(1, 0, 2, 32'hFFFF_FFFF, "R5 clear all");
    op(1, 0, 6, 32'hFFFF_FFFF, "R5 clear all");
    op(1, 0, 8, 32'hFFFF_FFFF, "R7 swi write");
    idle(3);
    rd_all("R7 swi nonmaskable");
    op(1, 0, 8, 32'h0000_0002, "R7 swi normal only");
    idle(2);
    rd_all("R7 swi normal");
    // R9 writes to read-only / unmapped
    op(1, 0, 0, 32'hFFFF_FFFF, "R9 ro write");
    op(1, 0, 3, 32'hFFFF_FFFF, "R9 ro write");
    op(1, 0, 7, 32'hFFFF_FFFF, "R9 ro write");
    op(1, 0, 12, 32'hFFFF_FFFF, "R9 unmapped write");
    rd_all("R9 unchanged after ro writes");
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 10));
      op($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, $urandom,
         "R1 R2 R5 R6 R7 R9 random");
      if ($urandom_range(0, 3) == 0) src = (N-2)'($urandom);
    end
    idle(4);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule